// File: doc/BRIEF.md
# Addend-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for a precision time protocol engine, without needing a reference clock that matches the nominal tick rate. On every reference clock edge a 32-bit addend is summed into a 32-bit phase accumulator. Each time that sum wraps past 2^32, the block produces one nominal tick, and the nanosecond counter advances by a programmable tick period. Software trims the rate by changing the addend, which is normally set to ceil(2^32 / R), where R is the ratio of reference frequency to nominal frequency. R must be greater than 1. For example, an addend of 0x999999A4 with a 10 ns period gives 100 MHz ticks.

A programmable divider counts the nominal ticks and produces a slower one-cycle enable. For example, a divide of 100 on a 10 ns tick gives a strobe every microsecond. A small synchronous register port writes the addend, the period and the divide value. It also loads the counter atomically and reads it as two coherent 32-bit halves.

Top module: `drift_trim_timer`

## Requirements
- R1: Every cycle the accumulator adds the addend modulo 2^32. An edge whose sum reaches 2^32 or more is a carry, and `tick_o` is high for exactly the one cycle after that edge. Starting from a cleared accumulator, N additions of addend A give floor(N*A/2^32) ticks.
- R2: Each carry edge that carries no counter load adds the tick period (register select 1) to the 64-bit counter. With no carry and no load, the counter holds its value.
- R3: The divider counts carries. `slow_tick_o` is high for one cycle, in the same cycle as the `tick_o` of every P-th carry, where P is the divide value (register select 2). A divide value of 0 or 1 gives a strobe on every tick. After T ticks from reset, the number of strobes is floor(T/P).
- R4: A write to the addend (register select 0) changes the sum from the following edge onward. The write does not clear the accumulator, so its phase carries over into the new rate.
- R5: A write to select 3 stages the low 32 bits of a load value. A write to select 4 loads {written data, staged low} into the counter at that edge. The load wins over a carry on the same edge.
- R6: A read of select 5 returns the low half of the counter and latches the whole 64-bit value. A read of select 6 returns the high half of that latched value, even if the counter has moved since.
- R7: Reads of selects 0, 1 and 2 return the addend, the period and the divide value. A read of select 7 returns 0. Read data appears on `rd_data` in the cycle after the edge at which `rd_en` is sampled.
- R8: Synchronous reset clears the accumulator, the counter, the divider count and both strobes. It also sets the addend to 0, the period to 0 and the divide value to 1.
- R9: The counter carries from bit 31 into bit 32, so time readings across a 2^32 ns boundary are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Registered read data |
| tick_o | output | 1 | One-cycle nominal tick strobe |
| slow_tick_o | output | 1 | One-cycle divided tick strobe |

## Verification
The hardest case to reach is a counter load that lands on the same edge as an accumulator carry, because carries depend on the accumulated phase rather than on anything directly visible. The bench sets the addend to 0xFFFFFFFF, which makes every addition after the first carry, so the edge of the high-half load write is known to carry. The bench also freezes the phase by writing a zero addend at a counted edge. Exact tick counts can then be compared with floor(N*A/2^32), and readings are taken while the counter stands still.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDEND   = 3'd0,
    SEL_PERIOD   = 3'd1,
    SEL_DIVIDE   = 3'd2,
    SEL_LOAD_LO  = 3'd3,
    SEL_LOAD_HI  = 3'd4,
    SEL_TIME_LO  = 3'd5,
    SEL_TIME_HI  = 3'd6,
    SEL_NONE     = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/dtt_phase_acc.sv
module dtt_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] addend_i,
  output logic             carry_o,
  output logic             tick_o,
  output logic [ACC_W-1:0] phase_o
);
  function automatic logic [ACC_W:0] wide_sum(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W-1:0] phase_q;
  logic             tick_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w   = wide_sum(phase_q, addend_i);
  assign carry_o = sum_w[ACC_W];
  assign tick_o  = tick_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= sum_w[ACC_W-1:0];
      tick_q  <= carry_o;
    end
  end

  AST_WRAP_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> (phase_q < $past(phase_q))); // R1
  AST_NO_WRAP_GROWS: assert property (@(posedge clk) disable iff (rst)
    !carry_o |=> (phase_q >= $past(phase_q))); // R1
endmodule

// File: rtl/dtt_ns_counter.sv
module dtt_ns_counter #(
  parameter int NS_W  = 64,
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             load_i,
  input  logic [NS_W-1:0]  load_val_i,
  output logic [NS_W-1:0]  ns_o
);
  function automatic logic [NS_W-1:0] advance(input logic [NS_W-1:0] now,
                                               input logic [PER_W-1:0] per);
    return now + NS_W'(per);
  endfunction

  logic [NS_W-1:0] ns_q;
  assign ns_o = ns_q;

  always_ff @(posedge clk) begin
    if (rst)          ns_q <= '0;
    else if (load_i)  ns_q <= load_val_i;
    else if (step_i)  ns_q <= advance(ns_q, period_i);
  end

  AST_STEP_ADDS_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (ns_q == $past(ns_q) + NS_W'($past(period_i)))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(ns_q)); // R2
  AST_LOAD_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ns_q == $past(load_val_i))); // R5
endmodule

// File: rtl/dtt_divider.sv
module dtt_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [DIV_W-1:0] divide_i,
  output logic             strobe_o
);
  function automatic logic at_last(input logic [DIV_W-1:0] cnt,
                                   input logic [DIV_W-1:0] div);
    return (div <= DIV_W'(1)) || (cnt >= div - DIV_W'(1));
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic             strobe_q;
  logic             wrap_w;

  assign wrap_w   = step_i && at_last(cnt_q, divide_i);
  assign strobe_o = strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= wrap_w;
      if (wrap_w)      cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_STROBE_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(step_i)); // R3
  AST_COUNT_MOVES_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    step_i |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + DIV_W'(1)))); // R3
  AST_COUNT_STILL: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/drift_trim_timer.sv
module drift_trim_timer
  import dtt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_o,
  output logic              slow_tick_o
);
  localparam int NS_W = 2 * DATA_W;

  logic [DATA_W-1:0] addend_q, period_q, divide_q, lo_stage_q, snap_hi_q, rd_q;
  logic [DATA_W-1:0] rd_next;
  logic [NS_W-1:0]   ns_w, load_val_w;
  logic [DATA_W-1:0] phase_w;
  logic              carry_w, load_w, snap_w;

  // Decoded write events
  assign load_w     = wr_en && (wr_addr == SEL_LOAD_HI);
  assign load_val_w = {wr_data, lo_stage_q};
  assign snap_w     = rd_en && (rd_addr == SEL_TIME_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      addend_q   <= '0;
      period_q   <= '0;
      divide_q   <= DATA_W'(1);
      lo_stage_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        SEL_ADDEND:  addend_q   <= wr_data;
        SEL_PERIOD:  period_q   <= wr_data;
        SEL_DIVIDE:  divide_q   <= wr_data;
        SEL_LOAD_LO: lo_stage_q <= wr_data;
        default: ;
      endcase
    end
  end

  dtt_phase_acc #(.ACC_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .addend_i(addend_q),
    .carry_o(carry_w), .tick_o(tick_o), .phase_o(phase_w)
  );

  dtt_ns_counter #(.NS_W(NS_W), .PER_W(DATA_W)) u_ns (
    .clk(clk), .rst(rst), .step_i(carry_w), .period_i(period_q),
    .load_i(load_w), .load_val_i(load_val_w), .ns_o(ns_w)
  );

  dtt_divider #(.DIV_W(DATA_W)) u_div (
    .clk(clk), .rst(rst), .step_i(carry_w), .divide_i(divide_q),
    .strobe_o(slow_tick_o)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      SEL_ADDEND:  rd_next = addend_q;
      SEL_PERIOD:  rd_next = period_q;
      SEL_DIVIDE:  rd_next = divide_q;
      SEL_LOAD_LO: rd_next = lo_stage_q;
      SEL_TIME_LO: rd_next = ns_w[DATA_W-1:0];
      SEL_TIME_HI: rd_next = snap_hi_q;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      snap_hi_q <= '0;
    end else begin
      if (rd_en)  rd_q      <= rd_next;
      if (snap_w) snap_hi_q <= ns_w[NS_W-1:DATA_W];
    end
  end

  assign rd_data = rd_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ns_w == '0 && phase_w == '0 && !tick_o && !slow_tick_o)); // R8
  AST_DIVIDED_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
    slow_tick_o |-> tick_o); // R3
  AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !snap_w |=> $stable(snap_hi_q)); // R6
endmodule

// File: tb/drift_trim_timer_test.sv
`timescale 1ns/1ps
module drift_trim_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_o, slow_tick_o;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;
  int slow_cnt = 0;

  always #2 clk = ~clk;

  drift_trim_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_o(tick_o), .slow_tick_o(slow_tick_o)
  );

  always @(negedge clk) begin
    if (tick_o)      tick_cnt = tick_cnt + 1;
    if (slow_tick_o) slow_cnt = slow_cnt + 1;
  end

  // addend, period, divide, additions
  localparam logic [127:0] VECS [6] = '{
    {32'h999999A4, 32'd10,        32'd7,   32'd100},
    {32'h80000000, 32'd7,         32'd1,   32'd51},
    {32'hFFFFFFFF, 32'd3,         32'd0,   32'd1000},
    {32'h00000001, 32'd5,         32'd3,   32'd10},
    {32'h40000000, 32'd1000000,   32'd250, 32'd4000},
    {32'hFFFFFFFF, 32'h80000000,  32'd4,   32'd10}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Caller stands at a negedge; returns at the next negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo);
    rd(3'd6, hi);
    t = {hi, lo};
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    int t0, s0;

    // Reset state, R8
    do_reset();
    check("R8 tick after reset", {63'd0, tick_o}, 64'd0);
    check("R8 divided tick after reset", {63'd0, slow_tick_o}, 64'd0);
    read_time(t);
    check("R8 counter after reset", t, 64'd0);
    rd(3'd2, d); check("R8 divide default", {32'd0, d}, 64'd1);
    rd(3'd0, d); check("R8 addend default", {32'd0, d}, 64'd0);

    // Vector walk: R1 R2 R3 R9
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, per, dv, n;
      logic [63:0] exp_ticks, exp_ns, exp_slow;
      {a, per, dv, n} = VECS[i];
      do_reset();
      wr(3'd2, dv);
      wr(3'd1, per);
      t0 = tick_cnt; s0 = slow_cnt;
      wr(3'd0, a);
      for (int k = 1; k < int'(n); k++) @(negedge clk);
      wr(3'd0, 32'd0);
      repeat (2) @(negedge clk);
      exp_ticks = (64'(n) * 64'(a)) >> 32;
      exp_ns    = exp_ticks * 64'(per);
      exp_slow  = (dv <= 32'd1) ? exp_ticks : exp_ticks / 64'(dv);
      check("R1 tick count", 64'(tick_cnt - t0), exp_ticks);
      check("R3 divided count", 64'(slow_cnt - s0), exp_slow);
      read_time(t);
      check((i == 5) ? "R9 counter across 2^32" : "R2 counter value", t, exp_ns);
    end

    // R7 readback
    do_reset();
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h999999A4);
    rd(3'd0, d); check("R7 addend readback", {32'd0, d}, 64'h999999A4);
    rd(3'd1, d); check("R7 period readback", {32'd0, d}, 64'd10);
    rd(3'd2, d); check("R7 divide readback", {32'd0, d}, 64'd100);
    rd(3'd7, d); check("R7 unused select reads zero", {32'd0, d}, 64'd0);

    // R4 phase kept across addend change; R1 tick timing
    do_reset();
    wr(3'd1, 32'd1);
    t0 = tick_cnt;
    wr(3'h0, 32'hC0000000);
    wr(3'h0, 32'h40000000);
    check("R1 no tick before wrap", {63'd0, tick_o}, 64'd0);
    wr(3'h0, 32'h00000000);
    check("R1 tick in cycle after carry", {63'd0, tick_o}, 64'd1);
    @(negedge clk);
    check("R1 tick lasts one cycle", {63'd0, tick_o}, 64'd0);
    check("R4 phase kept after addend write", 64'(tick_cnt - t0), 64'd1);
    read_time(t);
    check("R4 counter after phase carry", t, 64'd1);

    // R5 load on a carry edge wins
    do_reset();
    wr(3'd1, 32'd4);
    wr(3'd0, 32'hFFFFFFFF);
    wr(3'd3, 32'h00000100);
    wr(3'd4, 32'h00000007);
    wr(3'd0, 32'd0);
    read_time(t);
    check("R5 load beats carry", t, 64'h00000007_00000104);

    // R6 snapshot coherence
    rd(3'd5, d);
    check("R6 low half", {32'd0, d}, 64'h00000104);
    wr(3'd3, 32'h00000055);
    wr(3'd4, 32'h00000009);
    rd(3'd6, d);
    check("R6 high half from snapshot", {32'd0, d}, 64'd7);
    read_time(t);
    check("R5 new load value", t, 64'h00000009_00000055);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule